// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block is the arbiter of load-linked / store-conditional pairs for a cluster of processors. Each processor may hold one reservation, made of the exact byte address of its last load-linked access and a valid flag. The monitor watches, every cycle, the load-linked, store-conditional, ordinary store and context-clear strobes of all processors. It decides for each store-conditional whether it may take effect.

A passing store-conditional is forwarded to the memory side with its address and data. A failing one is dropped. The issuing processor gets a one-bit verdict on the cycle after its request.

Conflicts are judged per reservation granule. The granule is an aligned power-of-two block whose size is set by a parameter between 8 and 2048 bytes. A write anywhere inside the granule breaks every reservation that lies in it. A winning store-conditional counts as such a write.

Top module: `llsc_resv_monitor`

## Requirements
- R1: After reset no processor holds a reservation and `rsp_valid` and `mem_we` are low; a store-conditional issued straight after reset fails.
- R2: A store-conditional passes when its processor's reservation is valid, it targets the exact loaded address, and no clearing event intervened. One cycle later `rsp_fail` is 0, `mem_we` is 1, and `mem_addr`/`mem_wdata` carry the request's address and data.
- R3: A store-conditional from a processor without a reservation fails (`rsp_fail` = 1) and its `mem_we` stays 0.
- R4: A new load-linked replaces the processor's previous reservation: a store-conditional to the old address fails and one to the new address passes.
- R5: An ordinary store by any processor, the holder included, clears every reservation in the same granule. Two addresses share a granule when they are equal after a right shift by log2(GRANULE_BYTES). A store outside the granule, even to the adjacent byte, leaves the reservation intact.
- R6: `ctx_clr` clears only its own processor's reservation. A store-conditional issued in the same cycle as its processor's `ctx_clr` fails.
- R7: A store-conditional to an address other than the loaded one fails, even inside the same granule.
- R8: Every store-conditional, passing or failing, clears the issuing processor's reservation.
- R9: A passing store-conditional clears other processors' reservations in its granule in the same cycle.
- R10: Of several store-conditionals to one granule in the same cycle, only the lowest processor index can pass. Those to other granules are judged independently.
- R11: An ordinary store to a reservation's granule in the same cycle as that processor's store-conditional makes the store-conditional fail.
- R12: `rsp_valid[p]` is high exactly in the cycle after each store-conditional of processor p and low otherwise. `rsp_fail` encodes 0 for pass and 1 for fail.
- R13: Within one cycle, `ctx_clr` takes priority over a load-linked of the same processor, and a load-linked takes priority over a store that hits its own granule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_valid | input | NPROC | Load-linked strobe per processor |
| ll_addr | input | NPROC*ADDR_W | Load-linked byte address per processor |
| sc_valid | input | NPROC | Store-conditional strobe per processor |
| sc_addr | input | NPROC*ADDR_W | Store-conditional byte address per processor |
| sc_wdata | input | NPROC*DATA_W | Store-conditional write data per processor |
| st_valid | input | NPROC | Ordinary store strobe per processor |
| st_addr | input | NPROC*ADDR_W | Ordinary store byte address per processor |
| ctx_clr | input | NPROC | Context-switch clear pulse per processor |
| rsp_valid | output | NPROC | Store-conditional verdict valid |
| rsp_fail | output | NPROC | Verdict: 0 pass, 1 fail |
| mem_we | output | NPROC | Forwarded write enable of a passing store-conditional |
| mem_addr | output | NPROC*ADDR_W | Forwarded write address |
| mem_wdata | output | NPROC*DATA_W | Forwarded write data |

## Verification
The verdict path is driven with single-processor sequences that isolate one clearing cause at a time: a repeat load, a store inside the granule, a store one byte past each edge, an own-store, a context clear, and an exact-address mismatch. Each pair of sequences separates the address comparison from the granule comparison. Same-cycle patterns then set several store-conditionals on one granule against others on a different granule, which separates the index priority from plain granule matching. A passing store-conditional followed by a neighbour's store-conditional shows whether a win acts as a snoop write. Mixed ctx/LL and LL/store cycles pin down the order of the next-state rules.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  // Next-state action chosen for one reservation slot.
  typedef enum logic [1:0] {
    SLOT_HOLD = 2'd0,
    SLOT_LOAD = 2'd1,
    SLOT_DROP = 2'd2
  } slot_act_e;

  // True when two byte addresses fall in the same aligned granule.
  function automatic logic same_granule(input logic [63:0] a,
                                        input logic [63:0] b,
                                        input int unsigned lsb);
    return (a >> lsb) == (b >> lsb);
  endfunction

endpackage

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_req,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              sc_req,
  input  logic              ctx_clr,
  input  logic              snoop_clr,
  output logic              resv_valid,
  output logic [ADDR_W-1:0] resv_addr
);

  slot_act_e act;
  logic      valid_d;
  logic      addr_en;

  // Priority: context clear, then new load, then own SC or snooped write.
  always_comb begin
    if (ctx_clr)                  act = SLOT_DROP;
    else if (ll_req)              act = SLOT_LOAD;
    else if (sc_req || snoop_clr) act = SLOT_DROP;
    else                          act = SLOT_HOLD;
  end

  always_comb begin
    addr_en = 1'b0;
    valid_d = resv_valid;
    unique case (act)
      SLOT_LOAD: begin
        valid_d = 1'b1;
        addr_en = 1'b1;
      end
      SLOT_DROP: valid_d = 1'b0;
      default:   valid_d = resv_valid;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resv_valid <= 1'b0;
    else        resv_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (addr_en) resv_addr <= ll_addr;
  end

  AST_CTX_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_clr |=> !resv_valid); // R6

  AST_SC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !ll_req) |=> !resv_valid); // R8

  AST_LL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_req && !ctx_clr) |=> (resv_valid && resv_addr == $past(ll_addr))); // R4

endmodule

// File: rtl/llsc_snoop.sv
module llsc_snoop
  import llsc_pkg::*;
#(
  parameter int NPROC    = 4,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 6
) (
  input  logic [NPROC-1:0]        wr_valid,
  input  logic [NPROC*ADDR_W-1:0] wr_addr,
  input  logic [NPROC*ADDR_W-1:0] resv_addr,
  output logic [NPROC-1:0]        hit
);

  // hit[i]: some write this cycle lands in the granule of reservation i.
  always_comb begin
    for (int i = 0; i < NPROC; i++) begin
      hit[i] = 1'b0;
      for (int j = 0; j < NPROC; j++) begin
        if (wr_valid[j] &&
            same_granule(64'(wr_addr[j*ADDR_W +: ADDR_W]),
                         64'(resv_addr[i*ADDR_W +: ADDR_W]),
                         GRAN_LSB))
          hit[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/llsc_sc_arbiter.sv
module llsc_sc_arbiter
  import llsc_pkg::*;
#(
  parameter int NPROC    = 4,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPROC-1:0]        sc_valid,
  input  logic [NPROC*ADDR_W-1:0] sc_addr,
  input  logic [NPROC-1:0]        resv_valid,
  input  logic [NPROC*ADDR_W-1:0] resv_addr,
  input  logic [NPROC-1:0]        ctx_clr,
  input  logic [NPROC-1:0]        store_hit,
  output logic [NPROC-1:0]        win
);

  logic [NPROC-1:0] cand;
  logic [NPROC-1:0] blocked;

  // A candidate holds an intact reservation on the exact address.
  always_comb begin
    for (int i = 0; i < NPROC; i++) begin
      cand[i] = sc_valid[i] && resv_valid[i] && !ctx_clr[i] && !store_hit[i] &&
                (sc_addr[i*ADDR_W +: ADDR_W] == resv_addr[i*ADDR_W +: ADDR_W]);
    end
  end

  // Lower index candidates on the same granule take precedence.
  always_comb begin
    for (int i = 0; i < NPROC; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (cand[j] &&
            same_granule(64'(sc_addr[j*ADDR_W +: ADDR_W]),
                         64'(sc_addr[i*ADDR_W +: ADDR_W]),
                         GRAN_LSB))
          blocked[i] = 1'b1;
      end
    end
  end

  assign win = cand & ~blocked;

  for (genvar i = 0; i < NPROC; i++) begin : g_pair_i
    for (genvar j = i + 1; j < NPROC; j++) begin : g_pair_j
      AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(win[i] && win[j] &&
          same_granule(64'(sc_addr[i*ADDR_W +: ADDR_W]),
                       64'(sc_addr[j*ADDR_W +: ADDR_W]), GRAN_LSB))); // R10
    end
  end

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
  import llsc_pkg::*;
#(
  parameter int NPROC         = 4,
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int GRANULE_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPROC-1:0]        ll_valid,
  input  logic [NPROC*ADDR_W-1:0] ll_addr,
  input  logic [NPROC-1:0]        sc_valid,
  input  logic [NPROC*ADDR_W-1:0] sc_addr,
  input  logic [NPROC*DATA_W-1:0] sc_wdata,
  input  logic [NPROC-1:0]        st_valid,
  input  logic [NPROC*ADDR_W-1:0] st_addr,
  input  logic [NPROC-1:0]        ctx_clr,
  output logic [NPROC-1:0]        rsp_valid,
  output logic [NPROC-1:0]        rsp_fail,
  output logic [NPROC-1:0]        mem_we,
  output logic [NPROC*ADDR_W-1:0] mem_addr,
  output logic [NPROC*DATA_W-1:0] mem_wdata
);

  localparam int GRAN_LSB = $clog2(GRANULE_BYTES);

  logic [NPROC-1:0]        resv_valid;
  logic [NPROC*ADDR_W-1:0] resv_addr;
  logic [NPROC-1:0]        store_hit;
  logic [NPROC-1:0]        win_hit;
  logic [NPROC-1:0]        win;
  logic [NPROC-1:0]        rsp_valid_d;
  logic [NPROC-1:0]        rsp_fail_d;
  logic [NPROC-1:0]        mem_we_d;

  // Reservations broken by ordinary stores of any processor.
  llsc_snoop #(
    .NPROC(NPROC), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)
  ) u_store_snoop (
    .wr_valid  (st_valid),
    .wr_addr   (st_addr),
    .resv_addr (resv_addr),
    .hit       (store_hit)
  );

  llsc_sc_arbiter #(
    .NPROC(NPROC), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .sc_valid   (sc_valid),
    .sc_addr    (sc_addr),
    .resv_valid (resv_valid),
    .resv_addr  (resv_addr),
    .ctx_clr    (ctx_clr),
    .store_hit  (store_hit),
    .win        (win)
  );

  // Reservations broken by winning store-conditionals.
  llsc_snoop #(
    .NPROC(NPROC), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)
  ) u_win_snoop (
    .wr_valid  (win),
    .wr_addr   (sc_addr),
    .resv_addr (resv_addr),
    .hit       (win_hit)
  );

  for (genvar p = 0; p < NPROC; p++) begin : g_slot
    llsc_resv_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .ll_req     (ll_valid[p]),
      .ll_addr    (ll_addr[p*ADDR_W +: ADDR_W]),
      .sc_req     (sc_valid[p]),
      .ctx_clr    (ctx_clr[p]),
      .snoop_clr  (store_hit[p] | win_hit[p]),
      .resv_valid (resv_valid[p]),
      .resv_addr  (resv_addr[p*ADDR_W +: ADDR_W])
    );
  end

  always_comb begin
    rsp_valid_d = sc_valid;
    rsp_fail_d  = sc_valid & ~win;
    mem_we_d    = win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_fail  <= '0;
      mem_we    <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_fail  <= rsp_fail_d;
      mem_we    <= mem_we_d;
    end
  end

  for (genvar p = 0; p < NPROC; p++) begin : g_fwd
    always_ff @(posedge clk) begin
      if (win[p]) begin
        mem_addr[p*ADDR_W +: ADDR_W]  <= sc_addr[p*ADDR_W +: ADDR_W];
        mem_wdata[p*DATA_W +: DATA_W] <= sc_wdata[p*DATA_W +: DATA_W];
      end
    end

    AST_RSP_FOLLOWS_SC: assert property (@(posedge clk) disable iff (!rst_n)
      sc_valid[p] |=> rsp_valid[p]); // R12

    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !sc_valid[p] |=> !rsp_valid[p]); // R12

    AST_WRITE_MEANS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we[p] |-> (rsp_valid[p] && !rsp_fail[p])); // R2

    AST_WIN_NEEDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
      win[p] |-> resv_valid[p]); // R3
  end

endmodule

// File: tb/llsc_resv_monitor_tb.sv
module llsc_resv_monitor_tb;

  localparam int NP = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [31:0] DPAT = 32'hA5A5_0000;

  localparam logic [2:0] OP_LL  = 3'd0;
  localparam logic [2:0] OP_SC  = 3'd1;
  localparam logic [2:0] OP_ST  = 3'd2;
  localparam logic [2:0] OP_CTX = 3'd3;

  typedef struct packed {
    logic [1:0]  proc;
    logic [2:0]  op;
    logic [31:0] addr;
    logic        exp_fail;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VT [NV] = '{
    '{2'd0, OP_LL,  32'h100, 1'b0, 4'd2},
    '{2'd0, OP_SC,  32'h100, 1'b0, 4'd2},   // R2 pass
    '{2'd0, OP_SC,  32'h100, 1'b1, 4'd8},   // R8 reservation consumed
    '{2'd1, OP_SC,  32'h200, 1'b1, 4'd3},   // R3 none held
    '{2'd1, OP_LL,  32'h200, 1'b0, 4'd4},
    '{2'd1, OP_LL,  32'h300, 1'b0, 4'd4},
    '{2'd1, OP_SC,  32'h200, 1'b1, 4'd4},   // R4 old address gone
    '{2'd1, OP_LL,  32'h300, 1'b0, 4'd4},
    '{2'd1, OP_SC,  32'h300, 1'b0, 4'd4},   // R4 new address
    '{2'd2, OP_LL,  32'h400, 1'b0, 4'd5},
    '{2'd3, OP_ST,  32'h43F, 1'b0, 4'd5},
    '{2'd2, OP_SC,  32'h400, 1'b1, 4'd5},   // R5 last byte of granule
    '{2'd2, OP_LL,  32'h400, 1'b0, 4'd5},
    '{2'd3, OP_ST,  32'h440, 1'b0, 4'd5},
    '{2'd2, OP_SC,  32'h400, 1'b0, 4'd5},   // R5 next granule
    '{2'd2, OP_LL,  32'h400, 1'b0, 4'd5},
    '{2'd1, OP_ST,  32'h3FC, 1'b0, 4'd5},
    '{2'd2, OP_SC,  32'h400, 1'b0, 4'd5},   // R5 previous granule
    '{2'd3, OP_LL,  32'h500, 1'b0, 4'd5},
    '{2'd3, OP_ST,  32'h504, 1'b0, 4'd5},
    '{2'd3, OP_SC,  32'h500, 1'b1, 4'd5},   // R5 own store
    '{2'd0, OP_LL,  32'h600, 1'b0, 4'd6},
    '{2'd0, OP_CTX, 32'h0,   1'b0, 4'd6},
    '{2'd0, OP_SC,  32'h600, 1'b1, 4'd6},   // R6 context clear
    '{2'd0, OP_LL,  32'h600, 1'b0, 4'd7},
    '{2'd0, OP_SC,  32'h604, 1'b1, 4'd7},   // R7 address mismatch
    '{2'd1, OP_LL,  32'h700, 1'b0, 4'd6},
    '{2'd0, OP_CTX, 32'h0,   1'b0, 4'd6},
    '{2'd1, OP_SC,  32'h700, 1'b0, 4'd6}    // R6 other processor untouched
  };

  logic             clk;
  logic             rst_n;
  logic [NP-1:0]    ll_valid, sc_valid, st_valid, ctx_clr;
  logic [NP*AW-1:0] ll_addr, sc_addr, st_addr;
  logic [NP*DW-1:0] sc_wdata;
  logic [NP-1:0]    rsp_valid, rsp_fail, mem_we;
  logic [NP*AW-1:0] mem_addr;
  logic [NP*DW-1:0] mem_wdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  llsc_resv_monitor #(
    .NPROC(NP), .ADDR_W(AW), .DATA_W(DW), .GRANULE_BYTES(64)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ll_valid(ll_valid), .ll_addr(ll_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_wdata(sc_wdata),
    .st_valid(st_valid), .st_addr(st_addr),
    .ctx_clr(ctx_clr),
    .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    ll_valid = '0; sc_valid = '0; st_valid = '0; ctx_clr = '0;
    ll_addr = '0; sc_addr = '0; st_addr = '0; sc_wdata = '0;
  endtask

  task automatic set_ll(input int p, input logic [31:0] a);
    ll_valid[p] = 1'b1; ll_addr[p*AW +: AW] = a;
  endtask

  task automatic set_sc(input int p, input logic [31:0] a);
    sc_valid[p] = 1'b1; sc_addr[p*AW +: AW] = a;
    sc_wdata[p*DW +: DW] = a ^ DPAT;
  endtask

  task automatic set_st(input int p, input logic [31:0] a);
    st_valid[p] = 1'b1; st_addr[p*AW +: AW] = a;
  endtask

  // Verdict check for processor p, one cycle after its SC.
  task automatic expect_sc(input int p, input logic [31:0] a,
                           input bit fail, input string req);
    check(rsp_valid[p] == 1'b1, req, 64'(rsp_valid[p]), 64'd1);
    check(rsp_fail[p] == fail, req, 64'(rsp_fail[p]), 64'(fail));
    check(mem_we[p] == !fail, req, 64'(mem_we[p]), 64'(!fail));
    if (!fail) begin
      check(mem_addr[p*AW +: AW] == a, req, 64'(mem_addr[p*AW +: AW]), 64'(a));
      check(mem_wdata[p*DW +: DW] == (a ^ DPAT), req,
            64'(mem_wdata[p*DW +: DW]), 64'(a ^ DPAT));
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clear_in();
    rst_n = 1'b0;
    repeat (3) tick();
    // R1: idle outputs during reset
    check(rsp_valid == '0, "R1", 64'(rsp_valid), 64'd0);
    check(mem_we == '0, "R1", 64'(mem_we), 64'd0);
    rst_n = 1'b1;
    tick();
    check(rsp_valid == '0, "R1", 64'(rsp_valid), 64'd0);

    // R1: no reservation after reset
    for (int p = 0; p < NP; p++) set_sc(p, 32'h40 * p);
    tick();
    clear_in();
    for (int p = 0; p < NP; p++) expect_sc(p, 32'h40 * p, 1'b1, "R1");

    // Vector table
    for (int k = 0; k < NV; k++) begin
      clear_in();
      case (VT[k].op)
        OP_LL:   set_ll(VT[k].proc, VT[k].addr);
        OP_SC:   set_sc(VT[k].proc, VT[k].addr);
        OP_ST:   set_st(VT[k].proc, VT[k].addr);
        default: ctx_clr[VT[k].proc] = 1'b1;
      endcase
      tick();
      if (VT[k].op == OP_SC)
        expect_sc(VT[k].proc, VT[k].addr, VT[k].exp_fail, $sformatf("R%0d vec%0d", VT[k].req, k));
      else
        check(rsp_valid == '0, $sformatf("R12 vec%0d", k), 64'(rsp_valid), 64'd0);
    end
    clear_in();
    tick();
    // R12: verdict lasts one cycle only
    check(rsp_valid == '0, "R12", 64'(rsp_valid), 64'd0);
    check(mem_we == '0, "R12", 64'(mem_we), 64'd0);

    // R10: simultaneous SCs, two on one granule, one elsewhere
    set_ll(1, 32'h800); set_ll(2, 32'h810); set_ll(3, 32'h900);
    tick();
    clear_in();
    set_sc(1, 32'h800); set_sc(2, 32'h810); set_sc(3, 32'h900);
    tick();
    clear_in();
    expect_sc(1, 32'h800, 1'b0, "R10");
    expect_sc(2, 32'h810, 1'b1, "R10");
    expect_sc(3, 32'h900, 1'b0, "R10");
    check(rsp_valid[0] == 1'b0, "R12", 64'(rsp_valid[0]), 64'd0);

    // R9: winning SC breaks a neighbour's reservation, not a distant one
    set_ll(0, 32'hA00); set_ll(2, 32'hA08); set_ll(3, 32'hB40);
    tick();
    clear_in();
    set_sc(0, 32'hA00);
    tick();
    clear_in();
    expect_sc(0, 32'hA00, 1'b0, "R9");
    set_sc(2, 32'hA08); set_sc(3, 32'hB40);
    tick();
    clear_in();
    expect_sc(2, 32'hA08, 1'b1, "R9");
    expect_sc(3, 32'hB40, 1'b0, "R9");

    // R11: store in the SC's own cycle
    set_ll(1, 32'hB00);
    tick();
    clear_in();
    set_sc(1, 32'hB00); set_st(0, 32'hB20);
    tick();
    clear_in();
    expect_sc(1, 32'hB00, 1'b1, "R11");

    // R6: ctx clear in the SC's own cycle
    set_ll(3, 32'hD00);
    tick();
    clear_in();
    set_sc(3, 32'hD00); ctx_clr[3] = 1'b1;
    tick();
    clear_in();
    expect_sc(3, 32'hD00, 1'b1, "R6");

    // R13: ctx beats LL in the same cycle
    set_ll(0, 32'hC80); ctx_clr[0] = 1'b1;
    tick();
    clear_in();
    set_sc(0, 32'hC80);
    tick();
    clear_in();
    expect_sc(0, 32'hC80, 1'b1, "R13");

    // R13: LL beats a store to its granule in the same cycle
    set_ll(2, 32'hC00); set_st(1, 32'hC00);
    tick();
    clear_in();
    set_sc(2, 32'hC00);
    tick();
    clear_in();
    expect_sc(2, 32'hC00, 1'b0, "R13");

    tick();
    finish_run();
  end

endmodule